// File: doc/BRIEF.md
# Timed Test Coprocessor

This block is a test-support coprocessor for exercising a processor core's stall and interrupt paths. It holds sixteen 32-bit general registers that the core loads and reads with move-to and move-from transfers. Data-operation commands then use one of those registers as an operand. A command can stall the core for that many cycles, or drop the fast or normal interrupt line (both active low) after that many cycles. Other commands raise either line again, or copy a free-running cycle count into a register.

The core presents one command per cycle. The command carries a kind, a 4-bit opcode field (instruction bits 23:20), a 4-bit transfer register index (instruction bits 19:16) and a 4-bit operand register index (instruction bits 3:0). Responses come one cycle later as a done or reject pulse, with read data on `rdata_o`. While a stall is in progress the block reports busy and takes no new commands.

Top module: `timed_test_copro`

## Requirements
- R1: After reset both interrupt lines are high, busy, done and reject are low, and every register reads as zero.
- R2: A write command (kind 0) stores `cmd_wdata_i` into the register named by `cmd_reg_i`. A read command (kind 1) returns that register on `rdata_o` with a done pulse in the cycle after acceptance.
- R3: A data operation (kind 2) with an opcode above 5, or any command of kind 3, gives a reject pulse in the next cycle. It changes no register and no interrupt line.
- R4: Opcode 0 with operand value N>0 holds `busy_o` high for exactly N cycles after the accepting edge, then pulses done for one cycle. With N=0, done follows in the next cycle and busy never rises.
- R5: A command presented while `busy_o` is high is ignored. It gives no response and writes nothing.
- R6: Opcode 1 with operand value N drives `fiq_no` low N cycles after the accepting edge. With N=0 it goes low after that edge.
- R7: Opcode 2 drives `irq_no` low with the same timing as R6.
- R8: A new schedule command for a line replaces any count still pending on that line.
- R9: Opcode 3 raises `fiq_no` and opcode 4 raises `irq_no` after the accepting edge. A release does not cancel a pending count, but it takes precedence over a count that expires in the same cycle.
- R10: Opcode 5 writes the cycle count into the operand register. The value is the number of clock edges since reset release, taken before the accepting edge.
- R11: Done and reject are never high together, and each is a one-cycle pulse per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_kind_i | input | 2 | 0 write, 1 read, 2 data operation, 3 reserved |
| cmd_op_i | input | 4 | Opcode field, instruction bits 23:20 |
| cmd_reg_i | input | 4 | Transfer register index, instruction bits 19:16 |
| cmd_src_i | input | 4 | Operand register index, instruction bits 3:0 |
| cmd_wdata_i | input | 32 | Write data for transfers |
| rdata_o | output | 32 | Read data, valid with the done pulse of a read |
| busy_o | output | 1 | Stall in progress |
| done_o | output | 1 | Command or stall completed |
| reject_o | output | 1 | Command not supported |
| fiq_no | output | 1 | Fast interrupt request, active low |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Done, reject and read data are registered, so they are due one cycle after the accepting edge. The bench drives each command at a falling edge and samples at the next falling edge. A stall of N keeps busy for N sampled cycles, and done is due at the sample after that. A scheduled line falls at the Nth sample after acceptance, so the bench checks the line at every sample of that window and not only at the end. Capture values are predicted from a bench edge counter read at the falling edge that presents the command.

// File: rtl/tcop_pkg.sv
package tcop_pkg;
  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_OP    = 2'd2;

  localparam logic [3:0] OP_STALL    = 4'd0;
  localparam logic [3:0] OP_FIQ_ARM  = 4'd1;
  localparam logic [3:0] OP_IRQ_ARM  = 4'd2;
  localparam logic [3:0] OP_FIQ_REL  = 4'd3;
  localparam logic [3:0] OP_IRQ_REL  = 4'd4;
  localparam logic [3:0] OP_STAMP    = 4'd5;

  localparam int LINE_FIQ = 0;
  localparam int LINE_IRQ = 1;
  localparam int NUM_LINES = 2;
endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tcop_stall.sv
module tcop_stall #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      done_o <= 1'b0;
      left_q <= len_i - 1'b1;
    end else if (busy_o) begin
      if (left_q == '0) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        left_q <= left_q - 1'b1;
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_ends_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_busy_done_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/tcop_line_timer.sv
module tcop_line_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             release_i,
  output logic             line_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             expire;

  assign expire = pend_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_no <= 1'b1;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (release_i) begin
      // release wins over an expiry in the same cycle; count keeps running
      line_no <= 1'b1;
      if (expire)      pend_q <= 1'b0;
      else if (pend_q) cnt_q  <= cnt_q - 1'b1;
    end else if (arm_i) begin
      if (delay_i == '0) begin
        line_no <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        cnt_q  <= delay_i;
        pend_q <= 1'b1;
      end
    end else if (expire) begin
      line_no <= 1'b0;
      pend_q  <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // shared by both lines (R6 fast, R7 normal)
  p_release_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> line_no);
  p_arm_zero_now_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !release_i && delay_i == '0) |=> !line_no);
  p_fall_has_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_no) |-> ($past(arm_i) || $past(pend_q)));
endmodule

// File: rtl/timed_test_copro.sv
module timed_test_copro
  import tcop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_reg_i,
  input  logic [IDX_W-1:0]  cmd_src_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              reject_o,
  output logic              fiq_no,
  output logic              irq_no
);
  logic              accept;
  logic              we;
  logic [IDX_W-1:0]  waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] xfer_val, src_val;
  logic              rd_load, ack, nack, stall_start, stall_done;
  logic [NUM_LINES-1:0] arm, rel, line_n;
  logic              ack_q, nack_q;
  logic [DATA_W-1:0] cyc_q;

  assign accept = cmd_valid_i && !busy_o;

  always_comb begin
    we = 1'b0; waddr = cmd_reg_i; wdata = cmd_wdata_i;
    rd_load = 1'b0; ack = 1'b0; nack = 1'b0; stall_start = 1'b0;
    arm = '0; rel = '0;
    if (accept) begin
      case (cmd_kind_i)
        KIND_WRITE: begin we = 1'b1; ack = 1'b1; end
        KIND_READ:  begin rd_load = 1'b1; ack = 1'b1; end
        KIND_OP: begin
          case (cmd_op_i)
            OP_STALL: begin
              if (src_val == '0) ack = 1'b1;
              else               stall_start = 1'b1;
            end
            OP_FIQ_ARM: begin arm[LINE_FIQ] = 1'b1; ack = 1'b1; end
            OP_IRQ_ARM: begin arm[LINE_IRQ] = 1'b1; ack = 1'b1; end
            OP_FIQ_REL: begin rel[LINE_FIQ] = 1'b1; ack = 1'b1; end
            OP_IRQ_REL: begin rel[LINE_IRQ] = 1'b1; ack = 1'b1; end
            OP_STAMP: begin
              we = 1'b1; waddr = cmd_src_i; wdata = cyc_q; ack = 1'b1;
            end
            default: nack = 1'b1;
          endcase
        end
        default: nack = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
      rdata_o <= '0;
      cyc_q   <= '0;
    end else begin
      ack_q  <= ack;
      nack_q <= nack;
      cyc_q  <= cyc_q + 1'b1;
      if (rd_load) rdata_o <= xfer_val;
    end
  end

  tcop_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(cmd_reg_i), .rdata_a_o(xfer_val),
    .raddr_b_i(cmd_src_i), .rdata_b_o(src_val)
  );

  tcop_stall #(.CNT_W(DATA_W)) u_stall (
    .clk_i, .rst_ni,
    .start_i(stall_start), .len_i(src_val),
    .busy_o, .done_o(stall_done)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tcop_line_timer #(.CNT_W(DATA_W)) u_timer (
      .clk_i, .rst_ni,
      .arm_i(arm[g]), .delay_i(src_val), .release_i(rel[g]),
      .line_no(line_n[g])
    );
  end

  assign fiq_no   = line_n[LINE_FIQ];
  assign irq_no   = line_n[LINE_IRQ];
  assign done_o   = ack_q | stall_done;
  assign reject_o = nack_q;

  p_resp_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && reject_o));
  p_reject_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> !reject_o);
  p_ignore_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> (!reject_o && !ack_q));
  p_bad_op_rejects_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_kind_i == KIND_OP && cmd_op_i > OP_STAMP) |=> reject_o);
endmodule

// File: tb/timed_test_copro_tb.sv
module timed_test_copro_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = '0;
  logic [3:0]  cmd_op = '0, cmd_reg = '0, cmd_src = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] rdata;
  logic        busy, done, reject, fiq_n, irq_n;

  int unsigned vecs = 0, errs = 0;
  logic [31:0] model [16];
  logic [31:0] edge_cnt = '0;
  logic [31:0] issue_cnt;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_cnt <= '0;
    else        edge_cnt <= edge_cnt + 1;

  timed_test_copro u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_op_i(cmd_op), .cmd_reg_i(cmd_reg), .cmd_src_i(cmd_src),
    .cmd_wdata_i(cmd_wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .reject_o(reject), .fiq_no(fiq_n), .irq_no(irq_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // Drive at a falling edge, accepted at the next rising edge, return one falling edge later.
  task automatic issue(input logic [1:0] k, input logic [3:0] op,
                       input logic [3:0] ri, input logic [3:0] si, input logic [31:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_op = op; cmd_reg = ri; cmd_src = si; cmd_wdata = wd;
    issue_cnt = edge_cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] val);
    issue(2'd0, 4'd0, idx, 4'd0, val);
    model[idx] = val;
    check("R2", "write done", {31'b0, done}, 32'd1);
  endtask

  task automatic rd(input string req, input logic [3:0] idx);
    issue(2'd1, 4'd0, idx, 4'd0, 32'h0);
    check(req, "read done", {31'b0, done}, 32'd1);
    check(req, "read data", rdata, model[idx]);
  endtask

  task automatic op(input logic [3:0] opc, input logic [3:0] src);
    issue(2'd2, opc, 4'd0, src, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "fiq", {31'b0, fiq_n}, 32'd1);
    check("R1", "irq", {31'b0, irq_n}, 32'd1);
    check("R1", "busy/done/reject", {29'b0, busy, done, reject}, 32'd0);
    rd("R1", 4'd0);
    rd("R1", 4'd15);

    // R2 random transfers
    for (int i = 0; i < 60; i++) begin
      logic [3:0] idx;
      idx = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) wr(idx, $urandom);
      else rd("R2", idx);
    end
    wr(4'd1, 32'hFFFF_FFFF);
    rd("R2", 4'd1);

    // R3 rejects, no side effects
    op(4'd6, 4'd1);
    check("R3", "reject op6", {30'b0, reject, done}, 32'd2);
    op(4'd15, 4'd1);
    check("R3", "reject op15", {30'b0, reject, done}, 32'd2);
    issue(2'd3, 4'd1, 4'd1, 4'd1, 32'h1234);
    check("R3", "reject kind3", {30'b0, reject, done}, 32'd2);
    check("R3", "lines untouched", {30'b0, fiq_n, irq_n}, 32'd3);
    rd("R3", 4'd1);

    // R4 zero-length stall
    wr(4'd9, 32'd0);
    op(4'd0, 4'd9);
    check("R4", "zero stall done", {30'b0, busy, done}, 32'd1);
    @(negedge clk);
    check("R4", "zero stall idle", {30'b0, busy, done}, 32'd0);

    // R4/R5 stall of 4 with a write attempted mid-stall
    wr(4'd3, 32'd4);
    wr(4'd5, 32'h0000_5555);
    op(4'd0, 4'd3);
    for (int i = 0; i < 4; i++) begin
      check("R4", "busy window", {30'b0, busy, done}, 32'd2);
      if (i == 2) check("R5", "no response while busy", {31'b0, reject}, 32'd0);
      if (i == 1) begin
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_reg = 4'd5; cmd_wdata = 32'hDEAD_BEEF;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R4", "stall end done", {30'b0, busy, done}, 32'd1);
    @(negedge clk);
    check("R4", "done single", {31'b0, done}, 32'd0);
    rd("R5", 4'd5);

    // R6 fast line, delay 3
    wr(4'd2, 32'd3);
    op(4'd1, 4'd2);
    for (int k = 0; k <= 4; k++) begin
      check("R6", "fiq timing", {31'b0, fiq_n}, (k >= 3) ? 32'd0 : 32'd1);
      @(negedge clk);
    end
    op(4'd3, 4'd0);
    check("R9", "fiq released", {31'b0, fiq_n}, 32'd1);

    // R6 zero delay
    op(4'd1, 4'd9);
    check("R6", "fiq immediate", {31'b0, fiq_n}, 32'd0);
    op(4'd3, 4'd0);
    check("R9", "fiq released", {31'b0, fiq_n}, 32'd1);

    // R7 normal line, delay 2
    wr(4'd6, 32'd2);
    op(4'd2, 4'd6);
    for (int k = 0; k <= 3; k++) begin
      check("R7", "irq timing", {31'b0, irq_n}, (k >= 2) ? 32'd0 : 32'd1);
      @(negedge clk);
    end
    op(4'd4, 4'd0);
    check("R9", "irq released", {31'b0, irq_n}, 32'd1);
    check("R9", "fiq unaffected", {31'b0, fiq_n}, 32'd1);

    // R8 reschedule shorter: 10 then 2
    wr(4'd4, 32'd10);
    op(4'd2, 4'd4);
    op(4'd2, 4'd6);
    for (int k = 0; k <= 3; k++) begin
      check("R8", "irq reschedule shorter", {31'b0, irq_n}, (k >= 2) ? 32'd0 : 32'd1);
      @(negedge clk);
    end
    op(4'd4, 4'd0);

    // R8 reschedule longer: 3 then 10
    op(4'd1, 4'd2);
    op(4'd1, 4'd4);
    for (int k = 0; k <= 10; k++) begin
      check("R8", "fiq reschedule longer", {31'b0, fiq_n}, (k >= 10) ? 32'd0 : 32'd1);
      @(negedge clk);
    end
    op(4'd3, 4'd0);

    // R9 release keeps a pending count running
    wr(4'd7, 32'd6);
    op(4'd1, 4'd7);
    op(4'd3, 4'd0);
    check("R9", "release while pending", {31'b0, fiq_n}, 32'd1);
    for (int k = 3; k <= 7; k++) begin
      @(negedge clk);
      check("R9", "pending still fires", {31'b0, fiq_n}, (k >= 6) ? 32'd0 : 32'd1);
    end
    op(4'd3, 4'd0);

    // R10 cycle capture, twice
    op(4'd5, 4'd11);
    model[11] = issue_cnt;
    check("R10", "capture done", {31'b0, done}, 32'd1);
    repeat (7) @(negedge clk);
    op(4'd5, 4'd12);
    model[12] = issue_cnt;
    rd("R10", 4'd11);
    rd("R10", 4'd12);

    // R11 pulses are single-cycle
    op(4'd8, 4'd0);
    check("R11", "reject only", {30'b0, reject, done}, 32'd2);
    @(negedge clk);
    check("R11", "pulse cleared", {30'b0, reject, done}, 32'd0);

    summary();
  end
endmodule